// File: doc/BRIEF.md
# Banked External Memory Mapper

This block widens the external data space of an 8-bit microcontroller from 256 bytes to a 128 kB RAM. The CPU programs it through a 4-bit I/O-expander style link. When the strobe falls, a command nibble carries an opcode and a port number. When the strobe rises, a data nibble follows. Three nibble registers hold the mapping state: a page register for address bits 11:8, a bank register for bits 15:12 (one 4 kB bank per value) and a control register. A separate flag holds address bit 16. Its value depends on the kind of write command: a plain write sets it, and an OR-write to the page or bank register clears it. One nibble transfer therefore loads a register and picks the upper or lower 64 kB.

During an external data access, the CPU places the low address byte on the multiplexed bus while the address-latch input is high. The block latches that byte and combines it with the mapping state into a 17-bit RAM address. Bit 3 of the control register switches a fixed I/O address window on or off. While the window is on, accesses that fall inside it raise the I/O select instead of the RAM select. While it is off, every address reaches RAM, so all 128 kB can be read and written. All outputs except the nibble read-back are registered.

Top module: `xmem_mapper`

## Requirements
- R1: After a synchronous reset, the page, bank and control registers and address bit 16 are zero. `ram_addr`, `ram_cs`, `io_cs` and `nib_oe` are low, and `io_win_en` is high.
- R2: A write command (opcode 2'b01) to port code 2'b00 (page), 2'b01 (bank) or 2'b11 (control) loads the data nibble into that register and sets address bit 16 to 1.
- R3: An OR command (opcode 2'b10) to the page or bank port loads the data nibble as given and clears address bit 16 to 0.
- R4: An AND command (opcode 2'b11) to any mapped port, and an OR command to the control port, load the data nibble and leave address bit 16 unchanged.
- R5: Any command to port code 2'b10 changes no register and does not change address bit 16.
- R6: During the data phase of a read command (opcode 2'b00) to a mapped port, `nib_oe` is high and `nib_out` carries that register. At all other times `nib_oe` is low and `nib_out` is zero.
- R7: `ram_addr` equals {bit16, bank, page, low byte} one clock after that state. The low byte is taken from `ad_in` on every clock in which `ale` is high.
- R8: While control bit 3 is 1, `io_cs` stays low, every access raises `ram_cs`, and `io_win_en` is low.
- R9: While control bit 3 is 0, an access whose address bits 16:8 equal the window page (default 9'h0FF) raises `io_cs` and keeps `ram_cs` low. Other accesses raise `ram_cs`.
- R10: `ram_cs` and `io_cs` are never high together, and both are low one clock after a cycle without `acc_req`.
- R11: The command nibble is taken on the clock that sees the strobe fall. The data nibble is taken on the clock that sees it rise, so the nibble on the bus in between has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exp_stb | input | 1 | Expander strobe: falling edge opens the command, rising edge closes data |
| nib_in | input | 4 | Nibble bus from CPU: {opcode, port} at fall, data at rise |
| nib_out | output | 4 | Read-back nibble |
| nib_oe | output | 1 | Drive enable for the read-back nibble |
| ale | input | 1 | Address latch enable for the low byte |
| ad_in | input | 8 | Multiplexed low address byte |
| acc_req | input | 1 | External data access in this cycle |
| ram_addr | output | 17 | RAM address |
| ram_cs | output | 1 | RAM select |
| io_cs | output | 1 | I/O window select |
| io_win_en | output | 1 | I/O window enabled |

## Verification
Directed sequences apply each opcode to each port in orders that make bit 16 alternate. This separates plain writes, OR-writes and AND-writes, which would look alike if only the loaded nibble were checked. A command nibble that differs from the following data nibble shows whether the block captures at the right strobe edge. Accesses inside and outside the window page, with the window switched on and off, separate the RAM and I/O decode paths. A long run of random commands and low bytes is then compared, clock by clock, with a behavioural model of all outputs.

// File: rtl/xmm_pkg.sv
package xmm_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_OR    = 2'b10,
    OP_AND   = 2'b11
  } xmm_op_e;

  typedef enum logic [1:0] {
    PT_PAGE  = 2'b00,
    PT_BANK  = 2'b01,
    PT_SPARE = 2'b10,
    PT_CTL   = 2'b11
  } xmm_port_e;

  typedef struct packed {
    xmm_op_e   op;
    xmm_port_e port;
  } xmm_cmd_t;
endpackage

// File: rtl/xmm_exp_decode.sv
module xmm_exp_decode
  import xmm_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stb,
  input  logic [NIB_W-1:0] nib_in,
  output xmm_cmd_t         cmd,
  output logic             phase,
  output logic             wr_stb,
  output logic [NIB_W-1:0] wr_data
);
  logic     stb_q;
  logic     phase_q;
  xmm_cmd_t cmd_q;
  logic     fall, rise;

  assign fall = stb_q & ~stb;
  assign rise = ~stb_q & stb & phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_q   <= 1'b1;
      phase_q <= 1'b0;
      cmd_q   <= '{op: OP_READ, port: PT_PAGE};
    end else begin
      stb_q <= stb;
      if (fall) begin
        cmd_q   <= xmm_cmd_t'(nib_in[3:0]);
        phase_q <= 1'b1;
      end else if (rise) begin
        phase_q <= 1'b0;
      end
    end
  end

  assign cmd     = cmd_q;
  assign phase   = phase_q;
  assign wr_stb  = rise && (cmd_q.op != OP_READ);
  assign wr_data = nib_in;
endmodule

// File: rtl/xmm_regfile.sv
module xmm_regfile
  import xmm_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_stb,
  input  xmm_cmd_t         cmd,
  input  logic             phase,
  input  logic [NIB_W-1:0] wr_data,
  output logic [NIB_W-1:0] page_q,
  output logic [NIB_W-1:0] bank_q,
  output logic [NIB_W-1:0] ctl_q,
  output logic             hi_q,
  output logic             rd_oe,
  output logic [NIB_W-1:0] rd_data
);
  localparam int NPORT = 4;
  logic [NPORT-1:0][NIB_W-1:0] regs;

  for (genvar p = 0; p < NPORT; p++) begin : g_reg
    if (p == int'(PT_SPARE)) begin : g_none
      assign regs[p] = '0;
    end else begin : g_store
      logic [NIB_W-1:0] r_q;
      always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else if (wr_stb && (cmd.port == xmm_port_e'(p))) r_q <= wr_data;
      end
      assign regs[p] = r_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= 1'b0;
    end else if (wr_stb) begin
      if (cmd.op == OP_WRITE && cmd.port != PT_SPARE)
        hi_q <= 1'b1;
      else if (cmd.op == OP_OR && (cmd.port == PT_PAGE || cmd.port == PT_BANK))
        hi_q <= 1'b0;
    end
  end

  assign page_q  = regs[PT_PAGE];
  assign bank_q  = regs[PT_BANK];
  assign ctl_q   = regs[PT_CTL];
  assign rd_oe   = phase && (cmd.op == OP_READ) && (cmd.port != PT_SPARE);
  assign rd_data = rd_oe ? regs[cmd.port] : '0;
endmodule

// File: rtl/xmm_addr_gen.sv
module xmm_addr_gen #(
  parameter int          NIB_W    = 4,
  parameter int          LO_W     = 8,
  parameter int          CTL_BIT  = 3,
  parameter int          ADDR_W   = 1 + 2*NIB_W + LO_W,
  parameter int          PG_W     = ADDR_W - LO_W,
  parameter logic [PG_W-1:0] WIN_PAGE = '1 >> 1,
  parameter logic [PG_W-1:0] WIN_MASK = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ale,
  input  logic [LO_W-1:0]   ad_in,
  input  logic              acc_req,
  input  logic              hi,
  input  logic [NIB_W-1:0]  bank,
  input  logic [NIB_W-1:0]  page,
  input  logic [NIB_W-1:0]  ctl,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_cs,
  output logic              io_cs,
  output logic              win_en
);
  logic [LO_W-1:0] lo_q;
  logic [PG_W-1:0] page_sel;
  logic            in_win, win_on, io_hit;

  assign page_sel = {hi, bank, page};
  assign in_win   = ((page_sel ^ WIN_PAGE) & WIN_MASK) == '0;
  assign win_on   = ~ctl[CTL_BIT];
  assign io_hit   = acc_req & win_on & in_win;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q     <= '0;
      ram_addr <= '0;
      ram_cs   <= 1'b0;
      io_cs    <= 1'b0;
      win_en   <= 1'b1;
    end else begin
      if (ale) lo_q <= ad_in;
      ram_addr <= {page_sel, lo_q};
      io_cs    <= io_hit;
      ram_cs   <= acc_req & ~io_hit;
      win_en   <= win_on;
    end
  end
endmodule

// File: rtl/xmem_mapper.sv
module xmem_mapper
  import xmm_pkg::*;
#(
  parameter int NIB_W   = 4,
  parameter int LO_W    = 8,
  parameter int CTL_BIT = 3,
  parameter int ADDR_W  = 1 + 2*NIB_W + LO_W,
  parameter int PG_W    = ADDR_W - LO_W,
  parameter logic [PG_W-1:0] WIN_PAGE = 9'h0FF,
  parameter logic [PG_W-1:0] WIN_MASK = 9'h1FF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exp_stb,
  input  logic [NIB_W-1:0]  nib_in,
  output logic [NIB_W-1:0]  nib_out,
  output logic              nib_oe,
  input  logic              ale,
  input  logic [LO_W-1:0]   ad_in,
  input  logic              acc_req,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_cs,
  output logic              io_cs,
  output logic              io_win_en
);
  xmm_cmd_t         cmd;
  logic             phase, wr_stb, hi_q;
  logic [NIB_W-1:0] wr_data, page_q, bank_q, ctl_q;

  xmm_exp_decode #(.NIB_W(NIB_W)) u_dec (
    .clk(clk), .rst(rst), .stb(exp_stb), .nib_in(nib_in),
    .cmd(cmd), .phase(phase), .wr_stb(wr_stb), .wr_data(wr_data)
  );

  xmm_regfile #(.NIB_W(NIB_W)) u_regs (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .cmd(cmd), .phase(phase),
    .wr_data(wr_data), .page_q(page_q), .bank_q(bank_q), .ctl_q(ctl_q),
    .hi_q(hi_q), .rd_oe(nib_oe), .rd_data(nib_out)
  );

  xmm_addr_gen #(
    .NIB_W(NIB_W), .LO_W(LO_W), .CTL_BIT(CTL_BIT), .ADDR_W(ADDR_W),
    .PG_W(PG_W), .WIN_PAGE(WIN_PAGE), .WIN_MASK(WIN_MASK)
  ) u_addr (
    .clk(clk), .rst(rst), .ale(ale), .ad_in(ad_in), .acc_req(acc_req),
    .hi(hi_q), .bank(bank_q), .page(page_q), .ctl(ctl_q),
    .ram_addr(ram_addr), .ram_cs(ram_cs), .io_cs(io_cs), .win_en(io_win_en)
  );
endmodule

// File: rtl/xmm_checker.sv
module xmm_checker
  import xmm_pkg::*;
#(
  parameter int NIB_W   = 4,
  parameter int CTL_BIT = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             acc_req,
  input logic             ram_cs,
  input logic             io_cs,
  input logic             nib_oe,
  input logic             wr_stb,
  input logic             phase,
  input xmm_cmd_t         cmd,
  input logic             hi_q,
  input logic [NIB_W-1:0] page_q,
  input logic [NIB_W-1:0] bank_q,
  input logic [NIB_W-1:0] ctl_q
);
  AST_CS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(ram_cs && io_cs)); // R10
  AST_IDLE_NO_SELECT: assert property (@(posedge clk) disable iff (rst) !acc_req |=> (!ram_cs && !io_cs)); // R10
  AST_WINDOW_OFF: assert property (@(posedge clk) disable iff (rst) (acc_req && ctl_q[CTL_BIT]) |=> (!io_cs && ram_cs)); // R8
  AST_WRITE_SETS_HI: assert property (@(posedge clk) disable iff (rst) (wr_stb && cmd.op == OP_WRITE && cmd.port != PT_SPARE) |=> hi_q); // R2
  AST_OR_CLEARS_HI: assert property (@(posedge clk) disable iff (rst) (wr_stb && cmd.op == OP_OR && (cmd.port == PT_PAGE || cmd.port == PT_BANK)) |=> !hi_q); // R3
  AST_AND_KEEPS_HI: assert property (@(posedge clk) disable iff (rst) (wr_stb && cmd.op == OP_AND) |=> $stable(hi_q)); // R4
  AST_SPARE_IGNORED: assert property (@(posedge clk) disable iff (rst) (wr_stb && cmd.port == PT_SPARE) |=> ($stable(hi_q) && $stable(page_q) && $stable(bank_q) && $stable(ctl_q))); // R5
  AST_OE_ONLY_READ: assert property (@(posedge clk) disable iff (rst) nib_oe |-> (phase && cmd.op == OP_READ)); // R6
endmodule

bind xmem_mapper xmm_checker #(.NIB_W(NIB_W), .CTL_BIT(CTL_BIT)) u_chk (
  .clk(clk), .rst(rst), .acc_req(acc_req), .ram_cs(ram_cs), .io_cs(io_cs),
  .nib_oe(nib_oe), .wr_stb(wr_stb), .phase(phase), .cmd(cmd), .hi_q(hi_q),
  .page_q(page_q), .bank_q(bank_q), .ctl_q(ctl_q)
);

// File: tb/xmem_mapper_tb_top.sv
`timescale 1ns/1ps
module xmem_mapper_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        exp_stb = 1'b1;
  logic [3:0]  nib_in = 4'h0;
  logic [3:0]  nib_out;
  logic        nib_oe;
  logic        ale = 1'b0;
  logic [7:0]  ad_in = 8'h00;
  logic        acc_req = 1'b0;
  logic [16:0] ram_addr;
  logic        ram_cs, io_cs, io_win_en;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  xmem_mapper dut_i (
    .clk(clk), .rst(rst), .exp_stb(exp_stb), .nib_in(nib_in),
    .nib_out(nib_out), .nib_oe(nib_oe), .ale(ale), .ad_in(ad_in),
    .acc_req(acc_req), .ram_addr(ram_addr), .ram_cs(ram_cs),
    .io_cs(io_cs), .io_win_en(io_win_en)
  );

  task automatic chk(input string tag, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  // Behavioural reference model
  int m_prev = 1, m_phase = 0, m_op = 0, m_port = 0;
  int m_page = 0, m_bank = 0, m_ctl = 0, m_hi = 0, m_lo = 0;
  int e_addr = 0, e_ram = 0, e_io = 0, e_win = 1;
  localparam int WIN_PG = 'h0FF;

  always @(posedge clk) begin
    if (rst) begin
      m_prev = 1; m_phase = 0; m_op = 0; m_port = 0;
      m_page = 0; m_bank = 0; m_ctl = 0; m_hi = 0; m_lo = 0;
      e_addr = 0; e_ram = 0; e_io = 0; e_win = 1;
    end else begin
      bit winon, inwin;
      e_addr = (m_hi << 16) | (m_bank << 12) | (m_page << 8) | m_lo;
      winon  = ((m_ctl >> 3) & 1) == 0;
      inwin  = (e_addr >> 8) == WIN_PG;
      e_io   = (acc_req && winon && inwin) ? 1 : 0;
      e_ram  = (acc_req && !e_io) ? 1 : 0;
      e_win  = winon ? 1 : 0;
      if (ale) m_lo = ad_in;
      if (m_prev == 1 && exp_stb == 0) begin
        m_op = nib_in >> 2; m_port = nib_in & 3; m_phase = 1;
      end else if (m_prev == 0 && exp_stb == 1 && m_phase == 1) begin
        m_phase = 0;
        if (m_op != 0) begin
          if (m_port == 0) m_page = nib_in;
          if (m_port == 1) m_bank = nib_in;
          if (m_port == 3) m_ctl = nib_in;
          if (m_op == 1 && m_port != 2) m_hi = 1;
          if (m_op == 2 && m_port < 2) m_hi = 0;
        end
      end
      m_prev = exp_stb;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      int oe_e, no_e;
      oe_e = (m_phase == 1 && m_op == 0 && m_port != 2) ? 1 : 0;
      no_e = 0;
      if (oe_e == 1) no_e = (m_port == 0) ? m_page : (m_port == 1) ? m_bank : m_ctl;
      chk("R7 ram_addr model", int'(ram_addr), e_addr);
      chk("R9 ram_cs model", int'(ram_cs), e_ram);
      chk("R9 io_cs model", int'(io_cs), e_io);
      chk("R8 io_win_en model", int'(io_win_en), e_win);
      chk("R6 nib_oe model", int'(nib_oe), oe_e);
      chk("R6 nib_out model", int'(nib_out), no_e);
    end
  end

  task automatic exp_cmd(input int op, input int port, input int data);
    @(negedge clk); exp_stb = 1'b0; nib_in = 4'((op << 2) | port);
    @(negedge clk);
    @(negedge clk); nib_in = 4'(data);
    @(negedge clk); exp_stb = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic access(input int lo);
    @(negedge clk); ale = 1'b1; ad_in = 8'(lo);
    @(negedge clk); ale = 1'b0; acc_req = 1'b1;
    @(negedge clk); acc_req = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 ram_addr", int'(ram_addr), 0);
    chk("R1 ram_cs", int'(ram_cs), 0);
    chk("R1 io_cs", int'(io_cs), 0);
    chk("R1 nib_oe", int'(nib_oe), 0);
    chk("R1 io_win_en", int'(io_win_en), 1);

    exp_cmd(1, 0, 4'h3);
    chk("R2 write page hi", int'(ram_addr[16]), 1);
    chk("R2 write page", int'(ram_addr[11:8]), 3);
    // R11: command nibble 0101 differs from data 1010
    exp_cmd(1, 1, 4'hA);
    chk("R11 bank takes data nibble", int'(ram_addr[15:12]), 'hA);
    exp_cmd(2, 0, 4'h5);
    chk("R3 or page hi", int'(ram_addr[16]), 0);
    chk("R3 or page", int'(ram_addr[11:8]), 5);
    exp_cmd(1, 3, 4'h0);
    chk("R2 write ctl hi", int'(ram_addr[16]), 1);
    exp_cmd(2, 1, 4'h1);
    chk("R3 or bank hi", int'(ram_addr[16]), 0);
    chk("R3 or bank", int'(ram_addr[15:12]), 1);
    exp_cmd(3, 0, 4'h9);
    chk("R4 and page keeps hi0", int'(ram_addr[16]), 0);
    chk("R4 and page", int'(ram_addr[11:8]), 9);
    exp_cmd(1, 0, 4'h9);
    exp_cmd(3, 1, 4'h2);
    chk("R4 and bank keeps hi1", int'(ram_addr[16]), 1);
    exp_cmd(2, 3, 4'h0);
    chk("R4 or ctl keeps hi1", int'(ram_addr[16]), 1);
    exp_cmd(2, 2, 4'hF);
    chk("R5 spare or", int'(ram_addr[16:8]), 'h129);
    exp_cmd(1, 2, 4'h7);
    chk("R5 spare write", int'(ram_addr[16:8]), 'h129);

    // R6 read back bank register during data phase
    @(negedge clk); exp_stb = 1'b0; nib_in = 4'b0001;
    @(negedge clk);
    @(negedge clk); nib_in = 4'h0;
    chk("R6 read oe", int'(nib_oe), 1);
    chk("R6 read data", int'(nib_out), 2);
    @(negedge clk); exp_stb = 1'b1;
    @(negedge clk);
    chk("R6 oe after rise", int'(nib_oe), 0);

    // Window page 0x0FF enabled
    exp_cmd(2, 1, 4'hF);
    exp_cmd(2, 0, 4'hF);
    access('h34);
    chk("R9 io hit", int'(io_cs), 1);
    chk("R9 ram off", int'(ram_cs), 0);
    chk("R7 addr", int'(ram_addr), 'h0FF34);
    @(negedge clk);
    chk("R10 idle ram", int'(ram_cs), 0);
    chk("R10 idle io", int'(io_cs), 0);
    exp_cmd(1, 3, 4'h8);
    exp_cmd(2, 0, 4'hF);
    access('h56);
    chk("R8 window off io", int'(io_cs), 0);
    chk("R8 window off ram", int'(ram_cs), 1);
    chk("R8 win_en low", int'(io_win_en), 0);
    chk("R7 addr off", int'(ram_addr), 'h0FF56);
    exp_cmd(1, 3, 4'h0);
    exp_cmd(2, 0, 4'hE);
    access('h10);
    chk("R9 outside window", int'(ram_cs), 1);
    chk("R9 outside io", int'(io_cs), 0);

    for (int i = 0; i < 400; i++) begin
      int r;
      r = int'($urandom);
      exp_cmd(r & 3, (r >> 2) & 3, (r >> 4) & 15);
      access((r >> 8) & 255);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule